// File: doc/BRIEF.md
# Systolic Matrix Multiplier

This block multiplies two square matrices of signed integers on a grid of multiply-accumulate cells, with C = A x B. Operands arrive one beat per cycle. In beat k, the row lanes carry column k of A and the column lanes carry row k of B. Registers at the left and top edges skew each lane, so that matching operand pairs meet in the correct cell. Operands move to the right and downward one cell per clock. A cell never talks to anything but its neighbours.

When a cell has seen the last beat of a problem, it parks its sum in a shadow register and restarts from zero. The next problem can therefore start accumulating in the very next cycle. Each column then copies its shadows into an unload chain. The chain shifts the results out at the bottom edge, one row per cycle. A small deskew triangle lines the columns up so that each output beat is one complete row. No multiplexer and no addressed storage sit in the result path.

A mode input turns the grid into a matrix-vector engine. Only lane 0 of the B side is used, and the other columns see zero.

Top module: `systolic_mm`

## Requirements
- R1: While rst_ni is low, and after release until the first result, out_valid_o is low and c_o is all zero.
- R2: Beats are the cycles with in_valid_i high, and every group of 4 beats forms one problem. Idle cycles between the beats of a group do not break the group. In beat k, lane r of a_i (bits r*16 +: 16) carries A[r][k] and lane c of b_i carries B[k][c]. Lane c of c_o (bits c*34 +: 34) carries the exact product element as 34-bit two's complement.
- R3: The first result row of a problem appears on c_o 8 cycles after its last beat, which is 11 cycles after the first beat when the beats are consecutive. The rows then follow one per cycle in the order 3, 2, 1, 0.
- R4: out_valid_o is high for exactly 4 cycles per problem, and only in the cycles that carry its rows.
- R5: When problems follow each other with no idle cycle, their result rows follow with no gap, and out_valid_o stays high throughout.
- R6: In a cycle with in_valid_i low, a_i, b_i and mv_mode_i are ignored and no accumulation happens. Idle cycles inside a problem only delay its results by the same number of cycles.
- R7: In a beat with mv_mode_i high, b_i lanes 1 to 3 count as zero. When mv_mode_i is high for all four beats, c_o lane 0 holds A times x, where x[k] is b_i lane 0 in beat k, and lanes 1 to 3 hold zero.
- R8: Extreme operands do not overflow. Four products of -32768 x -32768 give +2^32, and four products of 32767 x -32768 give their exact negative sum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operand beat present |
| mv_mode_i | input | 1 | Matrix-vector mode for this beat |
| a_i | input | 64 | Four 16-bit row lanes of A (lane r is A[r][k]) |
| b_i | input | 64 | Four 16-bit column lanes of B (lane c is B[k][c]) |
| out_valid_o | output | 1 | A result row is present on c_o |
| c_o | output | 136 | One result row, four 34-bit lanes |

## Verification
The two functions that can fall in the same cycle are the reload of a column's unload chain with a new problem's sums and the final shift of the previous problem's last row out of that chain. In the same window, the shadow capture of the new problem overlaps the accumulation of the one after it. Back-to-back problems provoke this, both directed and in long random streams with no idle cycles. The bench judges it by stamping every expected row with its exact output cycle, from R3. It then compares values row by row, so a lost, duplicated or shifted row shows up as a miscompare or as a stray or missing out_valid_o.

// File: rtl/sm_pkg.sv
package sm_pkg;
  typedef struct packed {
    logic vld;
    logic last;
  } sm_tag_t;

  function automatic int acc_w(int dw, int n);
    return 2 * dw + $clog2(n);
  endfunction
endpackage

// File: rtl/sm_delay.sv
module sm_delay #(
  parameter int W = 1,
  parameter int D = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [D];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < D; i++) st_q[i] <= '0;
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < D; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[D-1];
endmodule

// File: rtl/sm_pe.sv
module sm_pe
  import sm_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 34
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  sm_tag_t       tag_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output sm_tag_t       tag_o,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [AW-1:0] shadow_o
);
  logic signed [2*DW-1:0] prod;
  logic [AW-1:0] acc_q, sum;

  always_comb begin
    prod = $signed(a_i) * $signed(b_i);
    sum  = acc_q + {{(AW-2*DW){prod[2*DW-1]}}, prod};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_o    <= '0;
      a_o      <= '0;
      b_o      <= '0;
      acc_q    <= '0;
      shadow_o <= '0;
    end else begin
      tag_o <= tag_i;
      a_o   <= a_i;
      b_o   <= b_i;
      if (tag_i.vld) begin
        if (tag_i.last) begin
          shadow_o <= sum;
          acc_q    <= '0;
        end else begin
          acc_q <= sum;
        end
      end
    end
  end

  // R2
  acc_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tag_i.vld && tag_i.last) |=> (acc_q == '0));

  // R6
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tag_i.vld |=> $stable(acc_q));
endmodule

// File: rtl/sm_ctrl.sv
module sm_ctrl #(
  parameter int N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_valid_i,
  input  logic unload_i,
  output logic last_o,
  output logic out_valid_o
);
  localparam int BW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);

  logic [BW-1:0] beat_q;
  logic [CW-1:0] cnt_q;

  assign last_o      = in_valid_i && (beat_q == BW'(N - 1));
  assign out_valid_o = (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      beat_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (in_valid_i) beat_q <= last_o ? '0 : beat_q + BW'(1);
      if (unload_i)          cnt_q <= CW'(N);
      else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end
  end

  // R4
  unload_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unload_i |-> (cnt_q <= CW'(1)));

  // R2
  beat_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (beat_q == '0));
endmodule

// File: rtl/systolic_mm.sv
module systolic_mm
  import sm_pkg::*;
#(
  parameter int N  = 4,
  parameter int DW = 16,
  parameter int AW = sm_pkg::acc_w(DW, N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          mv_mode_i,
  input  logic [N*DW-1:0] a_i,
  input  logic [N*DW-1:0] b_i,
  output logic          out_valid_o,
  output logic [N*AW-1:0] c_o
);
  sm_tag_t tag_in;
  logic    beat_last;
  logic [N-1:0] done_bot;

  sm_tag_t [N-1:0]            t_sk;
  logic    [N-1:0][DW-1:0]    a_sk, b_sk;
  sm_tag_t [N-1:0][N-2:0]     t_h;
  logic    [N-1:0][N-2:0][DW-1:0] a_h;
  logic    [N-2:0][N-1:0][DW-1:0] b_h;
  logic    [N-1:0][N-1:0][AW-1:0] sh;

  sm_ctrl #(.N(N)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .unload_i   (done_bot[N-1]),
    .last_o     (beat_last),
    .out_valid_o(out_valid_o)
  );

  always_comb begin
    tag_in.vld  = in_valid_i;
    tag_in.last = beat_last;
  end

  // edge skew: row r and column c delayed by r and c cycles
  for (genvar r = 0; r < N; r++) begin : g_rsk
    if (r == 0) begin : g_d0
      assign a_sk[0] = a_i[DW-1:0];
      assign t_sk[0] = tag_in;
    end else begin : g_dn
      logic [DW+1:0] sk_q;
      sm_delay #(.W(DW + 2), .D(r)) u_dly (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .d_i  ({tag_in, a_i[r*DW +: DW]}),
        .q_o  (sk_q)
      );
      assign {t_sk[r], a_sk[r]} = sk_q;
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_csk
    if (c == 0) begin : g_d0
      assign b_sk[0] = b_i[DW-1:0];
    end else begin : g_dn
      logic [DW-1:0] b_g;
      assign b_g = mv_mode_i ? '0 : b_i[c*DW +: DW];
      sm_delay #(.W(DW), .D(c)) u_dly (
        .clk_i(clk_i), .rst_ni(rst_ni), .d_i(b_g), .q_o(b_sk[c])
      );
    end
  end

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      sm_tag_t t_in, t_out;
      logic [DW-1:0] a_in, b_in, a_out, b_out;

      if (c == 0) begin : g_al
        assign a_in = a_sk[r];
        assign t_in = t_sk[r];
      end else begin : g_an
        assign a_in = a_h[r][c-1];
        assign t_in = t_h[r][c-1];
      end

      if (r == 0) begin : g_bt
        assign b_in = b_sk[c];
      end else begin : g_bn
        assign b_in = b_h[r-1][c];
      end

      sm_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tag_i   (t_in),
        .a_i     (a_in),
        .b_i     (b_in),
        .tag_o   (t_out),
        .a_o     (a_out),
        .b_o     (b_out),
        .shadow_o(sh[r][c])
      );

      if (c < N - 1) begin : g_ap
        assign a_h[r][c] = a_out;
        assign t_h[r][c] = t_out;
      end else begin : g_ae
        logic [DW-1:0] a_unused;
        sm_tag_t       t_unused;
        assign a_unused = a_out;
        assign t_unused = t_out;
      end

      if (r < N - 1) begin : g_bp
        assign b_h[r][c] = b_out;
      end else begin : g_be
        logic [DW-1:0] b_unused;
        assign b_unused = b_out;
        // bottom cell shadow is fresh the cycle after its last beat
        assign done_bot[c] = t_out.vld && t_out.last;
      end
    end
  end

  // unload chain per column, then deskew so every beat is a full row
  for (genvar c = 0; c < N; c++) begin : g_unl
    logic [AW-1:0] col_q [N];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int r = 0; r < N; r++) col_q[r] <= '0;
      end else if (done_bot[c]) begin
        for (int r = 0; r < N; r++) col_q[r] <= sh[r][c];
      end else begin
        col_q[0] <= '0;
        for (int r = 1; r < N; r++) col_q[r] <= col_q[r-1];
      end
    end

    if (c == N - 1) begin : g_nd
      assign c_o[c*AW +: AW] = col_q[N-1];
    end else begin : g_ds
      sm_delay #(.W(AW), .D(N - 1 - c)) u_dsk (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .d_i  (col_q[N-1]),
        .q_o  (c_o[c*AW +: AW])
      );
    end

    if (c > 0) begin : g_wchk
      // R3
      wave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_bot[c] |-> $past(done_bot[c-1]));
    end
  end

  // R3
  out_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_bot[N-1] |=> out_valid_o);
endmodule

// File: tb/systolic_mm_bench.sv
module systolic_mm_bench;
  localparam int N  = 4;
  localparam int DW = 16;
  localparam int AW = 2 * DW + 2;
  localparam int CLK_PERIOD = 10;
  localparam int WDOG = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic rst_ni, in_valid, mv_mode, out_valid_o;
  logic [N*DW-1:0] a_i, b_i;
  logic [N*AW-1:0] c_o;

  systolic_mm u_systolic_mm (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .mv_mode_i(mv_mode),
    .a_i(a_i), .b_i(b_i), .out_valid_o(out_valid_o), .c_o(c_o)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, fails = 0;
  bit done_run = 1'b0;
  int exp_cyc[$];
  logic [N*AW-1:0] exp_row[$];
  string exp_tag[$];
  int ma[N][N], mb[N][N];

  function automatic int rnd16();
    logic [DW-1:0] v;
    v = DW'($urandom);
    return int'($signed(v));
  endfunction

  task automatic drive_idle();
    in_valid = 1'b0;
    mv_mode  = 1'($urandom);
    for (int l = 0; l < N; l++) begin
      a_i[l*DW +: DW] = DW'($urandom);
      b_i[l*DW +: DW] = DW'($urandom);
    end
    @(negedge clk);
  endtask

  task automatic run_prob(input bit mvm, input logic [N-1:0] gaps, input string tag);
    int t_last;
    longint s;
    logic [N*AW-1:0] row;
    t_last = 0;
    for (int k = 0; k < N; k++) begin
      if (k > 0 && gaps[k]) drive_idle();
      in_valid = 1'b1;
      mv_mode  = mvm;
      for (int r = 0; r < N; r++) a_i[r*DW +: DW] = DW'(ma[r][k]);
      for (int c = 0; c < N; c++) b_i[c*DW +: DW] = DW'(mb[k][c]);
      if (k == N - 1) t_last = cyc;
      @(negedge clk);
    end
    // R3: rows N-1..0 starting 8 cycles after the last beat
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < N; c++) begin
        s = 0;
        for (int k = 0; k < N; k++)
          s += longint'(ma[N-1-i][k]) * ((mvm && c != 0) ? 64'sd0 : longint'(mb[k][c]));
        row[c*AW +: AW] = s[AW-1:0];
      end
      exp_cyc.push_back(t_last + 8 + i);
      exp_row.push_back(row);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  always @(negedge clk) begin
    if (!done_run && rst_ni) begin
      if (out_valid_o) begin
        checks++;
        if (exp_cyc.size() == 0 || exp_cyc[0] != cyc) begin
          fails++;
          $display("FAIL R4: out_valid_o at cycle %0d act=1 exp=0", cyc);
        end else begin
          if (c_o !== exp_row[0]) begin
            fails++;
            $display("FAIL %s: row at cycle %0d act=%h exp=%h", exp_tag[0], cyc, c_o, exp_row[0]);
          end
          void'(exp_cyc.pop_front());
          void'(exp_row.pop_front());
          void'(exp_tag.pop_front());
        end
      end else if (exp_cyc.size() != 0 && exp_cyc[0] <= cyc) begin
        checks++;
        fails++;
        $display("FAIL %s: out_valid_o missing at cycle %0d act=0 exp=1", exp_tag[0], cyc);
        void'(exp_cyc.pop_front());
        void'(exp_row.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done_run) begin
      fails++;
      $display("FAIL R4: watchdog expired act=%0d exp=%0d", cyc, WDOG);
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5221));
    rst_ni = 1'b0; in_valid = 1'b0; mv_mode = 1'b0; a_i = '0; b_i = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0 || c_o !== '0) begin
      fails++;
      $display("FAIL R1: in reset act=%b/%h exp=0/0", out_valid_o, c_o);
    end
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid_o !== 1'b0 || c_o !== '0) begin
      fails++;
      $display("FAIL R1: after reset act=%b/%h exp=0/0", out_valid_o, c_o);
    end

    // R2 identity times random, then R5 back-to-back random
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = (r == c) ? 1 : 0;
        mb[r][c] = rnd16();
      end
    run_prob(1'b0, '0, "R2");
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = rnd16();
        mb[r][c] = rnd16();
      end
    run_prob(1'b0, '0, "R5");

    // R8 extremes
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = -32768;
        mb[r][c] = -32768;
      end
    run_prob(1'b0, '0, "R8");
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) ma[r][c] = 32767;
    run_prob(1'b0, '0, "R8");

    // R7 matrix-vector with junk on lanes 1..3
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        ma[r][c] = rnd16();
        mb[r][c] = rnd16();
      end
    run_prob(1'b1, '0, "R7");

    // R6 idle cycles inside a problem, garbage on the operand lanes
    drive_idle();
    run_prob(1'b0, 4'b1010, "R6");
    repeat (3) drive_idle();

    for (int n = 0; n < 40; n++) begin
      int g;
      bit mvm;
      logic [N-1:0] gp;
      string tg;
      g   = ($urandom % 4 == 0) ? int'($urandom % 3) + 1 : 0;
      mvm = ($urandom % 4 == 0);
      gp  = ($urandom % 5 == 0) ? (N'($urandom) & 4'b1110) : '0;
      repeat (g) drive_idle();
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          ma[r][c] = rnd16();
          mb[r][c] = rnd16();
        end
      tg = mvm ? "R7" : (gp != '0) ? "R6" : (g == 0) ? "R5" : "R2";
      run_prob(mvm, gp, tg);
    end

    repeat (20) drive_idle();
    checks++;
    if (exp_cyc.size() != 0) begin
      fails++;
      $display("FAIL R4: rows never delivered act=%0d exp=0", exp_cyc.size());
    end
    done_run = 1'b1;
    summary();
    $finish;
  end
endmodule